// File: doc/BRIEF.md
# Split Instruction/Data TLB Translator

This block turns a 32-bit virtual address into a physical address by consulting two direct-mapped translation tables side by side. One table holds instruction entries and the other holds data entries. Each entry is a pair of words. The match word carries the virtual page number and a valid flag. The translate word carries the physical page number and the access-permission flags. Both tables are indexed by the same low page-number bits. Both are read in the same cycle and their results are merged into a single permission mask.

A lookup is started by a one-cycle request strobe that carries the address, the access kind, the privilege level and a translation-enable flag. One cycle later the block presents the physical address, the granted rights, a completion pulse and, on a fault, an exception code. A fault also captures the offending address and pulses a signal that clears the load-link reservation. Software fills the tables through a single-word write port.

Top module: `split_tlb_xlate`

## Requirements
- R1: A lookup strobed on `req_i` at one rising edge produces a one-cycle `done_o` pulse after the next edge. The registered results then stay unchanged until the next lookup. Without a request, `done_o`, `fault_o` and `resv_clr_o` stay low.
- R2: The table index is `vaddr_i[18:13]`. The same index selects the instruction entry and the data entry. Another address with the same index but a different page number does not hit.
- R3: An entry hits when bits 31:13 of its match word equal bits 31:13 of the address. It counts as valid only when bit 0 of its match word is also set. An instruction hit makes execute valid, and a data hit makes read and write valid.
- R4: `prot_o` bit 0 is read, bit 1 is write and bit 2 is execute. Each flag comes from the translate words and is ANDed with the valid mask. Execute comes from instruction translate bit 6 in user mode and bit 7 in supervisor mode. In the data translate word, user read is bit 6, user write is bit 7, supervisor read is bit 8 and supervisor write is bit 9.
- R5: When bits 31:13 of the two translate words differ, the entry not used by the access is treated as all zero. A fetch drops the data entry, and a load or store drops the instruction entry.
- R6: `paddr_o[31:13]` is the OR of bits 31:13 of both translate words, after the R5 drop. `paddr_o[12:0]` equals `vaddr_i[12:0]`.
- R7: `kind_i` encodes 0 as fetch, 1 as load, 2 as store and 3 as load. The needed right is execute for a fetch, write for a store and read for a load. The access succeeds when that right is set in the rights mask.
- R8: A failed access raises `fault_o`. `excp_o` reports a page fault when the needed right is valid and a TLB miss otherwise. The codes are 0 none, 1 instruction page fault, 2 data page fault, 3 instruction TLB miss and 4 data TLB miss.
- R9: On a fault, `eear_o` captures the virtual address and `resv_clr_o` pulses for the same single cycle as `fault_o`. Otherwise `eear_o` keeps its value.
- R10: With `xlat_en_i` low, `paddr_o` equals the virtual address, `prot_o` is 7 and no fault is raised.
- R11: `wr_sel_i[1]` picks the table (0 instruction, 1 data) and `wr_sel_i[0]` picks the word (0 match, 1 translate). A write is seen only by lookups strobed after the write edge, not by a lookup in the same cycle.
- R12: After reset all outputs are zero and every table entry is zero, so any translated lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Lookup strobe |
| vaddr_i | input | 32 | Virtual address |
| kind_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 load |
| super_i | input | 1 | Supervisor privilege |
| xlat_en_i | input | 1 | Translation enable |
| wr_en_i | input | 1 | Table write strobe |
| wr_sel_i | input | 2 | Bit 1 table, bit 0 word |
| wr_idx_i | input | 6 | Entry index for write |
| wr_data_i | input | 32 | Write data |
| done_o | output | 1 | Lookup result valid pulse |
| fault_o | output | 1 | Lookup faulted pulse |
| excp_o | output | 3 | Exception code |
| paddr_o | output | 32 | Physical address |
| prot_o | output | 3 | Granted rights {exec, write, read} |
| eear_o | output | 32 | Captured faulting address |
| resv_clr_o | output | 1 | Reservation clear pulse |

## Verification
The hardest case to reach is a pair of instruction and data translate words at the same index whose physical page numbers disagree. Only that case makes the per-access drop rule decide between a page fault and a TLB miss. The stimulus builds it on purpose: it loads one index with conflicting page numbers and issues a fetch, a load and a store against it. The random phase then draws physical page numbers from a two-value pool, so conflicting and agreeing pairs keep recurring. That phase also restricts page numbers and indices to small pools, so that lookups hit and collide with recent writes, including writes made in the same cycle as a lookup.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned VA_W_DEF    = 32;
  localparam int unsigned PG_BITS_DEF = 13;
  localparam int unsigned IDX_W_DEF   = 6;

  // access kind encoding on kind_i (3 decodes as load)
  localparam logic [1:0] KIND_FETCH = 2'd0;
  localparam logic [1:0] KIND_STORE = 2'd2;

  // rights mask bit positions
  localparam int unsigned P_R = 0;
  localparam int unsigned P_W = 1;
  localparam int unsigned P_X = 2;

  // permission bit positions inside translate words
  localparam int unsigned TR_UXE = 6;
  localparam int unsigned TR_SXE = 7;
  localparam int unsigned TR_URE = 6;
  localparam int unsigned TR_UWE = 7;
  localparam int unsigned TR_SRE = 8;
  localparam int unsigned TR_SWE = 9;

  typedef enum logic [2:0] {
    EXC_NONE = 3'd0,
    EXC_IPF  = 3'd1,
    EXC_DPF  = 3'd2,
    EXC_ITLB = 3'd3,
    EXC_DTLB = 3'd4
  } excp_e;
endpackage

// File: rtl/tlb_way.sv
module tlb_way #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              wsel_tr_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [WORD_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [WORD_W-1:0] mr_o,
  output logic [WORD_W-1:0] tr_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [WORD_W-1:0] mr_q [DEPTH];
  logic [WORD_W-1:0] tr_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(DEPTH); i++) begin
        mr_q[i] <= '0;
        tr_q[i] <= '0;
      end
    end else if (we_i) begin
      if (wsel_tr_i) tr_q[widx_i] <= wdata_i;
      else           mr_q[widx_i] <= wdata_i;
    end
  end

  // read is combinational off the stored state: same-edge writes are not seen
  assign mr_o = mr_q[ridx_i];
  assign tr_o = tr_q[ridx_i];

  assert_write_lands_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> (($past(wsel_tr_i) ? tr_q[$past(widx_i)] : mr_q[$past(widx_i)]) == $past(wdata_i)));
endmodule

// File: rtl/tlb_eval.sv
module tlb_eval
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W    = 32,
  parameter int unsigned PG_BITS = 13
) (
  input  logic [VA_W-1:0] va_i,
  input  logic [1:0]      kind_i,
  input  logic            super_i,
  input  logic [VA_W-1:0] imr_i,
  input  logic [VA_W-1:0] itr_i,
  input  logic [VA_W-1:0] dmr_i,
  input  logic [VA_W-1:0] dtr_i,
  output logic [VA_W-1:0] paddr_o,
  output logic [2:0]      rights_o,
  output logic [2:0]      valid_o,
  output logic            ok_o,
  output excp_e           excp_o
);
  localparam int unsigned VPN_W = VA_W - PG_BITS;

  logic              fetch, store, split;
  logic [VPN_W-1:0]  va_vpn;
  logic [VA_W-1:0]   imr, itr, dmr, dtr;
  logic [2:0]        match, raw, need;

  always_comb begin
    fetch  = (kind_i == KIND_FETCH);
    store  = (kind_i == KIND_STORE);
    va_vpn = va_i[VA_W-1:PG_BITS];
    split  = (itr_i[VA_W-1:PG_BITS] != dtr_i[VA_W-1:PG_BITS]);
    imr = imr_i;
    itr = itr_i;
    dmr = dmr_i;
    dtr = dtr_i;
    // conflicting page frames: keep only the entry this access uses
    if (split) begin
      if (fetch) begin
        dmr = '0;
        dtr = '0;
      end else begin
        imr = '0;
        itr = '0;
      end
    end

    match      = '0;
    match[P_X] = (imr[VA_W-1:PG_BITS] == va_vpn);
    match[P_R] = (dmr[VA_W-1:PG_BITS] == va_vpn);
    match[P_W] = match[P_R];

    valid_o      = '0;
    valid_o[P_X] = match[P_X] & imr[0];
    valid_o[P_R] = match[P_R] & dmr[0];
    valid_o[P_W] = match[P_W] & dmr[0];

    raw      = '0;
    raw[P_X] = super_i ? itr[TR_SXE] : itr[TR_UXE];
    raw[P_R] = super_i ? dtr[TR_SRE] : dtr[TR_URE];
    raw[P_W] = super_i ? dtr[TR_SWE] : dtr[TR_UWE];
    rights_o = raw & valid_o;

    paddr_o = {itr[VA_W-1:PG_BITS] | dtr[VA_W-1:PG_BITS], va_i[PG_BITS-1:0]};

    need = '0;
    if (fetch)      need[P_X] = 1'b1;
    else if (store) need[P_W] = 1'b1;
    else            need[P_R] = 1'b1;

    ok_o = |(need & rights_o);
    if (ok_o)                  excp_o = EXC_NONE;
    else if (|(need & valid_o)) excp_o = fetch ? EXC_IPF : EXC_DPF;
    else                       excp_o = fetch ? EXC_ITLB : EXC_DTLB;
  end
endmodule

// File: rtl/split_tlb_xlate.sv
module split_tlb_xlate
  import tlb_pkg::*;
#(
  parameter int unsigned VA_W    = VA_W_DEF,
  parameter int unsigned PG_BITS = PG_BITS_DEF,
  parameter int unsigned IDX_W   = IDX_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [1:0]       kind_i,
  input  logic             super_i,
  input  logic             xlat_en_i,
  input  logic             wr_en_i,
  input  logic [1:0]       wr_sel_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [VA_W-1:0]  wr_data_i,
  output logic             done_o,
  output logic             fault_o,
  output logic [2:0]       excp_o,
  output logic [VA_W-1:0]  paddr_o,
  output logic [2:0]       prot_o,
  output logic [VA_W-1:0]  eear_o,
  output logic             resv_clr_o
);
  localparam int unsigned N_WAY = 2;

  logic [IDX_W-1:0] ridx;
  logic [VA_W-1:0]  rd_mr [N_WAY];
  logic [VA_W-1:0]  rd_tr [N_WAY];

  assign ridx = vaddr_i[PG_BITS +: IDX_W];

  // way 0 = instruction, way 1 = data
  for (genvar w = 0; w < int'(N_WAY); w++) begin : g_way
    tlb_way #(.WORD_W(VA_W), .IDX_W(IDX_W)) u_way (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .we_i     (wr_en_i && (wr_sel_i[1] == w[0])),
      .wsel_tr_i(wr_sel_i[0]),
      .widx_i   (wr_idx_i),
      .wdata_i  (wr_data_i),
      .ridx_i   (ridx),
      .mr_o     (rd_mr[w]),
      .tr_o     (rd_tr[w])
    );
  end

  logic [VA_W-1:0] ev_paddr;
  logic [2:0]      ev_rights, ev_valid;
  logic            ev_ok;
  excp_e           ev_excp;

  tlb_eval #(.VA_W(VA_W), .PG_BITS(PG_BITS)) u_eval (
    .va_i    (vaddr_i),
    .kind_i  (kind_i),
    .super_i (super_i),
    .imr_i   (rd_mr[0]),
    .itr_i   (rd_tr[0]),
    .dmr_i   (rd_mr[1]),
    .dtr_i   (rd_tr[1]),
    .paddr_o (ev_paddr),
    .rights_o(ev_rights),
    .valid_o (ev_valid),
    .ok_o    (ev_ok),
    .excp_o  (ev_excp)
  );

  logic            done_q, fault_q, resv_q;
  excp_e           excp_q;
  logic [VA_W-1:0] paddr_q, eear_q;
  logic [2:0]      prot_q;
  logic            miss_now;

  assign miss_now = req_i && xlat_en_i && !ev_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      resv_q  <= 1'b0;
      excp_q  <= EXC_NONE;
      paddr_q <= '0;
      prot_q  <= '0;
      eear_q  <= '0;
    end else begin
      done_q  <= req_i;
      fault_q <= miss_now;
      resv_q  <= miss_now;
      if (req_i) begin
        if (!xlat_en_i) begin
          paddr_q <= vaddr_i;
          prot_q  <= 3'b111;
          excp_q  <= EXC_NONE;
        end else begin
          paddr_q <= ev_paddr;
          prot_q  <= ev_rights;
          excp_q  <= ev_excp;
        end
      end
      if (miss_now) eear_q <= vaddr_i;
    end
  end

  assign done_o     = done_q;
  assign fault_o    = fault_q;
  assign resv_clr_o = resv_q;
  assign excp_o     = excp_q;
  assign paddr_o    = paddr_q;
  assign prot_o     = prot_q;
  assign eear_o     = eear_q;

  assert_done_follows_req_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> done_o);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!done_o && !fault_o && $stable(paddr_o) && $stable(prot_o)));
  assert_offset_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (paddr_o[PG_BITS-1:0] == $past(vaddr_i[PG_BITS-1:0])));
  assert_code_matches_fault_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (fault_o == (excp_o != EXC_NONE)));
  assert_fault_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (resv_clr_o && done_o && eear_o == $past(vaddr_i)));
  assert_bypass_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !xlat_en_i) |=> (!fault_o && prot_o == 3'b111 && paddr_o == $past(vaddr_i)));
  assert_fault_lacks_right_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> !(prot_o == 3'b111));
endmodule

// File: tb/test_split_tlb_xlate.sv
module test_split_tlb_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0;
  logic [31:0] va = '0;
  logic [1:0]  kind = '0;
  logic        sup = 1'b0;
  logic        en = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  wsel = '0;
  logic [5:0]  widx = '0;
  logic [31:0] wdata = '0;

  logic        done, fault, resv;
  logic [2:0]  excp, prot;
  logic [31:0] paddr, eear;

  int    vectors = 0;
  int    miscompares = 0;
  string phase = "R12";

  always #(CLK_PERIOD / 2) clk = ~clk;

  split_tlb_xlate i_split_tlb_xlate (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .vaddr_i(va), .kind_i(kind),
    .super_i(sup), .xlat_en_i(en), .wr_en_i(we), .wr_sel_i(wsel),
    .wr_idx_i(widx), .wr_data_i(wdata), .done_o(done), .fault_o(fault),
    .excp_o(excp), .paddr_o(paddr), .prot_o(prot), .eear_o(eear),
    .resv_clr_o(resv)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_mr [2][64];
  logic [31:0] m_tr [2][64];
  logic        e_done, e_fault, e_resv;
  logic [2:0]  e_excp, e_prot;
  logic [31:0] e_paddr, e_eear;

  task automatic model_lookup(input logic [31:0] a, input logic [1:0] k, input logic s);
    int idx;
    int vpn;
    logic [31:0] im, it, dm, dt;
    bit x_ok, d_ok, r, w, x, is_f, is_s, need_valid, have;
    idx  = int'((a >> 13) % 64);
    vpn  = int'(a >> 13);
    im = m_mr[0][idx]; it = m_tr[0][idx];
    dm = m_mr[1][idx]; dt = m_tr[1][idx];
    is_f = (k == 2'd0);
    is_s = (k == 2'd2);
    if ((it >> 13) != (dt >> 13)) begin
      if (is_f) begin dm = 0; dt = 0; end
      else      begin im = 0; it = 0; end
    end
    x_ok = (int'(im >> 13) == vpn) && im[0];
    d_ok = (int'(dm >> 13) == vpn) && dm[0];
    x = x_ok && (s ? it[7] : it[6]);
    r = d_ok && (s ? dt[8] : dt[6]);
    w = d_ok && (s ? dt[9] : dt[7]);
    e_prot  = {x, w, r};
    e_paddr = (((it | dt) >> 13) << 13) + (a % 8192);
    have = is_f ? x : (is_s ? w : r);
    need_valid = is_f ? x_ok : d_ok;
    if (have) e_excp = 3'd0;
    else if (need_valid) e_excp = is_f ? 3'd1 : 3'd2;
    else e_excp = is_f ? 3'd3 : 3'd4;
    if (!have) begin
      e_fault = 1'b1;
      e_resv  = 1'b1;
      e_eear  = a;
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 2; t++)
        for (int i = 0; i < 64; i++) begin
          m_mr[t][i] = '0;
          m_tr[t][i] = '0;
        end
      e_done = 0; e_fault = 0; e_resv = 0;
      e_excp = 0; e_prot = 0; e_paddr = 0; e_eear = 0;
    end else begin
      e_done  = req;
      e_fault = 0;
      e_resv  = 0;
      if (req) begin
        if (!en) begin
          e_paddr = va; e_prot = 3'b111; e_excp = 3'd0;
        end else begin
          model_lookup(va, kind, sup);
        end
      end
      if (we) begin
        if (wsel[0]) m_tr[wsel[1]][widx] = wdata;
        else         m_mr[wsel[1]][widx] = wdata;
      end
    end
  end

  // ---------------- comparison ----------------
  task automatic cmp(input string tag, input string field, input logic [31:0] act,
                     input logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s (phase %s) %s actual=%h expected=%h at %0t", tag, phase, field, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    vectors++;
    cmp("R1", "done_o", 32'(done), 32'(e_done));
    cmp("R8", "fault_o", 32'(fault), 32'(e_fault));
    cmp("R8", "excp_o", 32'(excp), 32'(e_excp));
    cmp("R6", "paddr_o", paddr, e_paddr);
    cmp("R4", "prot_o", 32'(prot), 32'(e_prot));
    cmp("R9", "eear_o", eear, e_eear);
    cmp("R9", "resv_clr_o", 32'(resv), 32'(e_resv));
  end

  // ---------------- stimulus helpers ----------------
  function automatic logic [31:0] mk_mr(input logic [18:0] vpn, input logic v);
    return {vpn, 12'h000, v};
  endfunction

  function automatic logic [31:0] mk_tr(input logic [18:0] ppn, input logic [3:0] perm);
    return {ppn, 3'b000, perm, 6'b000000};
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    req = 1'b0;
    we  = 1'b0;
  endtask

  task automatic put(input logic [1:0] s, input logic [5:0] i, input logic [31:0] d);
    we = 1'b1; wsel = s; widx = i; wdata = d;
  endtask

  task automatic ask(input logic [31:0] a, input logic [1:0] k, input logic s, input logic e);
    req = 1'b1; va = a; kind = k; sup = s; en = e;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired, actual=running expected=finished");
    finish_run();
  end

  localparam logic [18:0] VPN_A = 19'h00A07;  // index 7
  localparam logic [18:0] VPN_B = 19'h00409;  // index 9
  localparam logic [18:0] VPN_C = 19'h0150C;  // index 12

  initial begin
    // R12: reset state, then an empty-table lookup misses
    phase = "R12";
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    ask(32'h0000_0100, 2'd0, 1'b1, 1'b1); tick();
    ask(32'h1234_5678, 2'd2, 1'b0, 1'b1); tick();
    tick();

    // R11: write in the same cycle as a lookup is not seen by it
    phase = "R11";
    put(2'b10, 6'd7, mk_mr(VPN_A, 1'b1));
    ask({VPN_A, 13'h0040}, 2'd1, 1'b0, 1'b1); tick();
    ask({VPN_A, 13'h0040}, 2'd1, 1'b0, 1'b1); tick();
    put(2'b11, 6'd7, mk_tr(19'h12345, 4'b1111));
    ask({VPN_A, 13'h0044}, 2'd1, 1'b0, 1'b1); tick();
    ask({VPN_A, 13'h0044}, 2'd1, 1'b0, 1'b1); tick();

    // R4 / R7: privilege-selected permission bits, all kinds
    phase = "R4";
    put(2'b00, 6'd7, mk_mr(VPN_A, 1'b1)); tick();
    put(2'b01, 6'd7, mk_tr(19'h12345, 4'b0001)); tick();
    put(2'b11, 6'd7, mk_tr(19'h12345, 4'b0110)); tick();
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 2; s++) begin
        ask({VPN_A, 13'h1ABC}, 2'(k), 1'(s), 1'b1); tick();
      end
    phase = "R7";
    put(2'b01, 6'd7, mk_tr(19'h12345, 4'b0010)); tick();
    put(2'b11, 6'd7, mk_tr(19'h12345, 4'b1001)); tick();
    for (int k = 0; k < 4; k++)
      for (int s = 0; s < 2; s++) begin
        ask({VPN_A, 13'h0003}, 2'(k), 1'(s), 1'b1);
        tick();
        tick();
      end

    // R2: same index, other page number; neighbouring empty index
    phase = "R2";
    ask({19'h01A07, 13'h0010}, 2'd1, 1'b1, 1'b1); tick();
    ask({19'h01A07, 13'h0010}, 2'd0, 1'b1, 1'b1); tick();
    ask({19'h00A08, 13'h0010}, 2'd2, 1'b1, 1'b1); tick();

    // R3: clearing the valid bit turns a page fault into a miss
    phase = "R3";
    put(2'b10, 6'd7, mk_mr(VPN_A, 1'b0)); tick();
    ask({VPN_A, 13'h0020}, 2'd1, 1'b1, 1'b1); tick();
    ask({VPN_A, 13'h0020}, 2'd2, 1'b0, 1'b1); tick();
    ask({VPN_A, 13'h0020}, 2'd0, 1'b1, 1'b1); tick();

    // R5: conflicting frames drop the unused entry
    phase = "R5";
    put(2'b00, 6'd9, mk_mr(VPN_B, 1'b1)); tick();
    put(2'b01, 6'd9, mk_tr(19'h11111, 4'b0011)); tick();
    put(2'b10, 6'd9, mk_mr(VPN_B, 1'b1)); tick();
    put(2'b11, 6'd9, mk_tr(19'h22222, 4'b1111)); tick();
    for (int k = 0; k < 3; k++) begin
      ask({VPN_B, 13'h0777}, 2'(k), 1'b0, 1'b1); tick();
    end
    put(2'b11, 6'd9, mk_tr(19'h22222, 4'b0000)); tick();
    for (int k = 0; k < 3; k++) begin
      ask({VPN_B, 13'h0777}, 2'(k), 1'b1, 1'b1); tick();
    end

    // R6: agreeing frames, varied offsets, back-to-back
    phase = "R6";
    put(2'b00, 6'd12, mk_mr(VPN_C, 1'b1)); tick();
    put(2'b01, 6'd12, mk_tr(19'h0F0F0, 4'b0011)); tick();
    put(2'b10, 6'd12, mk_mr(VPN_C, 1'b1)); tick();
    put(2'b11, 6'd12, mk_tr(19'h0F0F0, 4'b1111)); tick();
    for (int o = 0; o < 6; o++) begin
      ask({VPN_C, 13'(o * 1337)}, 2'(o % 3), 1'(o % 2), 1'b1); tick();
    end

    // R10: translation disabled
    phase = "R10";
    ask(32'hDEAD_BEEF, 2'd2, 1'b0, 1'b0); tick();
    ask({VPN_A, 13'h0020}, 2'd0, 1'b0, 1'b0); tick();
    ask(32'h0000_0000, 2'd1, 1'b1, 1'b0); tick();
    tick();

    // R8 / R1: random mixed traffic
    phase = "R8";
    for (int n = 0; n < 4000; n++) begin
      logic [18:0] vpn;
      vpn = {13'($urandom_range(0, 1)), 6'($urandom_range(0, 7))};
      if ($urandom_range(0, 2) == 0) begin
        logic [1:0] s;
        s = 2'($urandom_range(0, 3));
        if (s[0]) put(s, vpn[5:0], mk_tr(19'($urandom_range(0, 1) * 19'h00155),
                                        4'($urandom_range(0, 15))));
        else      put(s, vpn[5:0], mk_mr(vpn, 1'($urandom_range(0, 3) != 0)));
      end
      if ($urandom_range(0, 3) != 0)
        ask({vpn, 13'($urandom)}, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 7) != 0));
      tick();
    end
    tick();
    finish_run();
  end
endmodule